// File: doc/BRIEF.md
# Post-Indexed Indirect Address Sequencer

This block drives the bus for the post-indexed indirect addressing mode of an 8-bit processor core. A start pulse hands it a zero-page pointer, the Y index and an access mode. It reads a two-byte base address out of page zero, adds Y and then issues the data access at the resulting 16-bit address. The data access is a read, a write, or a read-modify-write.

When adding Y carries into the high byte, the first access to the data page goes to an address whose low byte is already indexed but whose high byte is still the base high byte. That access is a dummy read. In read mode the dummy read happens only when the high byte actually changes. Write and modify modes always perform it.

The block also marks the cycle in which the core samples interrupts, returns the operand it read, and pulses done after the last access. Instruction decode and the arithmetic that produces modified or stored data sit outside the block. That data arrives on `mod_data`.

Top module: `ind_idx_seq`

## Requirements
- R1: The first bus access after an accepted start is a read at address {8'h00, pointer}.
- R2: The second access reads the base high byte at {8'h00, pointer+1}, where pointer+1 wraps inside page zero (pointer 8'hFF gives 16'h0000).
- R3: The effective address is the 16-bit base {high, low} plus the zero-extended Y value, modulo 2^16.
- R4: In read mode, when the low byte plus Y does not carry, the effective read directly follows the two pointer reads. The instruction then takes three accesses.
- R5: In read mode with a carry, a dummy read at {base high, (base low + Y) mod 256} comes before the effective read.
- R6: In write mode (mode 2'b01) the dummy read is always made. It is followed by exactly one write of `mod_data` to the effective address.
- R7: In modify mode (mode 2'b10) the dummy read is always made. It is followed by a read of the effective address, a write of that unchanged value, and a write of `mod_data`, all to the effective address.
- R8: `irq_sample` is high for exactly one cycle per instruction: the cycle just before the final access. In modify mode that is the cycle before the final write.
- R9: `done` is high for one cycle, in the cycle right after the final access. Outside accesses the bus idles with address 0, `bus_rnw` 1 and write data 0.
- R10: `start`, `mode`, `y_index` and `zp_ptr` are captured when a start is accepted. Changes to them while an instruction is running have no effect on that instruction.
- R11: Mode 2'b00 is read. Mode 2'b11 also behaves exactly as read and never writes.
- R12: Asserting `rst_n` low returns the block to idle at once, even in the middle of an instruction. The bus idles and `operand` clears to 0.
- R13: `operand` takes the data returned by the effective read (read and modify modes). It holds that value until the next effective read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Begin a sequence; accepted only while idle |
| mode | input | 2 | 00 read, 01 write, 10 modify, 11 read |
| y_index | input | DATA_W | Index added to the base |
| zp_ptr | input | DATA_W | Zero-page pointer operand |
| rd_data | input | DATA_W | Bus read data for the current access |
| mod_data | input | DATA_W | Data to store, or the modified value |
| bus_addr | output | 2*DATA_W | Bus address |
| bus_rnw | output | 1 | 1 = read, 0 = write |
| bus_wdata | output | DATA_W | Bus write data |
| operand | output | DATA_W | Value from the effective read |
| irq_sample | output | 1 | Interrupt sampling strobe |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The bench builds the block with the default DATA_W of 8, so the byte arithmetic has the same widths as the real addressing mode. At this width a pointer of 8'hFF is in reach and checks the zero-page wrap of the high-byte fetch. A base of 16'hFF02 plus 8'hFF is also in reach; it wraps the whole address space to 16'h0001. Index values near 8'hFF cover both the carry and no-carry paths in every mode.

// File: rtl/ia_seq_pkg.sv
package ia_seq_pkg;

  typedef enum logic [1:0] {
    M_READ     = 2'b00,
    M_WRITE    = 2'b01,
    M_MODIFY   = 2'b10,
    M_READ_ALT = 2'b11
  } ia_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PTR_LO,
    ST_PTR_HI,
    ST_DUMMY,
    ST_EFF_RD,
    ST_WR_BACK,
    ST_WR_FINAL,
    ST_DONE
  } ia_state_e;

endpackage

// File: rtl/ia_index_adder.sv
module ia_index_adder #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] ptr,
  input  logic [DATA_W-1:0] base_lo,
  input  logic [DATA_W-1:0] base_hi,
  input  logic [DATA_W-1:0] y_val,
  output logic [DATA_W-1:0] ptr_inc,
  output logic [DATA_W-1:0] idx_lo,
  output logic [DATA_W-1:0] hi_fixed,
  output logic              carry
);

  // Pointer increment wraps inside page zero by width truncation.
  always_comb begin
    ptr_inc           = ptr + {{(DATA_W-1){1'b0}}, 1'b1};
    {carry, idx_lo}   = {1'b0, base_lo} + {1'b0, y_val};
    hi_fixed          = base_hi + {{(DATA_W-1){1'b0}}, carry};
  end

endmodule

// File: rtl/ia_seq_ctrl.sv
module ia_seq_ctrl
  import ia_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      is_write,
  input  logic      is_modify,
  input  logic      carry,
  output ia_state_e state,
  output logic      accept,
  output logic      irq_sample,
  output logic      done
);

  ia_state_e state_d;
  logic      need_dummy;

  assign need_dummy = is_write | is_modify | carry;
  assign accept     = (state == ST_IDLE) & start;

  always_comb begin
    state_d = state;
    unique case (state)
      ST_IDLE:     if (start) state_d = ST_PTR_LO;
      ST_PTR_LO:   state_d = ST_PTR_HI;
      ST_PTR_HI:   state_d = need_dummy ? ST_DUMMY : ST_EFF_RD;
      ST_DUMMY:    state_d = is_write ? ST_WR_FINAL : ST_EFF_RD;
      ST_EFF_RD:   state_d = is_modify ? ST_WR_BACK : ST_DONE;
      ST_WR_BACK:  state_d = ST_WR_FINAL;
      ST_WR_FINAL: state_d = ST_DONE;
      ST_DONE:     state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_d;
  end

  // Strobe in the cycle before the last access of the sequence.
  always_comb begin
    irq_sample = ((state == ST_PTR_HI) & ~need_dummy) |
                 ((state == ST_DUMMY)  & ~is_modify)  |
                 (state == ST_WR_BACK);
    done       = (state == ST_DONE);
  end

  // R4: a read without carry skips straight to the effective read
  a_r4_direct_read: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PTR_HI && !is_write && !is_modify && !carry) |=> (state == ST_EFF_RD));

endmodule

// File: rtl/ind_idx_seq.sv
module ind_idx_seq
  import ia_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [1:0]            mode,
  input  logic [DATA_W-1:0]     y_index,
  input  logic [DATA_W-1:0]     zp_ptr,
  input  logic [DATA_W-1:0]     rd_data,
  input  logic [DATA_W-1:0]     mod_data,
  output logic [2*DATA_W-1:0]   bus_addr,
  output logic                  bus_rnw,
  output logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     operand,
  output logic                  irq_sample,
  output logic                  done
);

  localparam int ADDR_W = 2 * DATA_W;
  localparam logic [DATA_W-1:0] ZERO_PAGE = '0;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  ia_state_e         state;
  logic              accept;
  logic              carry;
  logic              is_write, is_modify;
  ia_mode_e          mode_q;
  logic [DATA_W-1:0] ptr_q, y_q, base_lo_q, base_hi_q, operand_q;
  logic [DATA_W-1:0] ptr_inc, idx_lo, hi_fixed;
  logic              en_cap, en_lo, en_hi, en_op;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign is_write  = (mode_q == M_WRITE);
  assign is_modify = (mode_q == M_MODIFY);

  ia_seq_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start      (start),
    .is_write   (is_write),
    .is_modify  (is_modify),
    .carry      (carry),
    .state      (state),
    .accept     (accept),
    .irq_sample (irq_sample),
    .done       (done)
  );

  ia_index_adder #(.DATA_W(DATA_W)) u_add (
    .ptr      (ptr_q),
    .base_lo  (base_lo_q),
    .base_hi  (base_hi_q),
    .y_val    (y_q),
    .ptr_inc  (ptr_inc),
    .idx_lo   (idx_lo),
    .hi_fixed (hi_fixed),
    .carry    (carry)
  );

  // Clock enables
  assign en_cap = accept;
  assign en_lo  = (state == ST_PTR_LO);
  assign en_hi  = (state == ST_PTR_HI);
  assign en_op  = (state == ST_EFF_RD);

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      mode_q    <= M_READ;
      ptr_q     <= '0;
      y_q       <= '0;
      base_lo_q <= '0;
      base_hi_q <= '0;
      operand_q <= '0;
    end else begin
      if (en_cap) begin
        mode_q <= ia_mode_e'(mode);
        ptr_q  <= zp_ptr;
        y_q    <= y_index;
      end
      if (en_lo) base_lo_q <= rd_data;
      if (en_hi) base_hi_q <= rd_data;
      if (en_op) operand_q <= rd_data;
    end
  end

  always_comb begin
    bus_addr  = '0;
    bus_rnw   = 1'b1;
    bus_wdata = '0;
    unique case (state)
      ST_PTR_LO:   bus_addr = {ZERO_PAGE, ptr_q};
      ST_PTR_HI:   bus_addr = {ZERO_PAGE, ptr_inc};
      ST_DUMMY:    bus_addr = {base_hi_q, idx_lo};
      ST_EFF_RD:   bus_addr = {hi_fixed, idx_lo};
      ST_WR_BACK: begin
        bus_addr  = {hi_fixed, idx_lo};
        bus_rnw   = 1'b0;
        bus_wdata = operand_q;
      end
      ST_WR_FINAL: begin
        bus_addr  = {hi_fixed, idx_lo};
        bus_rnw   = 1'b0;
        bus_wdata = mod_data;
      end
      default: ;
    endcase
  end

  assign operand = operand_q;

  // R1: the access after an accepted start lies in page zero and reads
  a_r1_zero_page_first: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state == ST_IDLE && start) |=> (bus_addr[ADDR_W-1:DATA_W] == ZERO_PAGE && bus_rnw));

  // R5: dummy read and following access share the indexed low byte
  a_r5_low_byte_kept: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state == ST_DUMMY) |=> (bus_addr[DATA_W-1:0] == $past(bus_addr[DATA_W-1:0])));

  // R7: writeback is followed by a second write at the same address
  a_r7_double_write: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state == ST_WR_BACK) |=> (!bus_rnw && $stable(bus_addr)));

  // R8: the sampling strobe leads done by two cycles
  a_r8_irq_before_last: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq_sample |=> ##1 done);

  // R9: done lasts one cycle
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |=> !done);

  // R11: read modes never drive a write
  a_r11_read_no_write: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state != ST_IDLE && (mode_q == M_READ || mode_q == M_READ_ALT)) |-> bus_rnw);

endmodule

// File: tb/ind_idx_seq_test.sv
module ind_idx_seq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [7:0]  y_index = 8'h00;
  logic [7:0]  zp_ptr = 8'h00;
  logic [7:0]  rd_data;
  logic [7:0]  mod_data = 8'h00;
  logic [15:0] bus_addr;
  logic        bus_rnw;
  logic [7:0]  bus_wdata;
  logic [7:0]  operand;
  logic        irq_sample;
  logic        done;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  logic [7:0] mem_zp = 8'h00, mem_lo = 8'h00, mem_hi = 8'h00;

  always #5 clk = ~clk;

  ind_idx_seq #(.DATA_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .y_index(y_index), .zp_ptr(zp_ptr), .rd_data(rd_data), .mod_data(mod_data),
    .bus_addr(bus_addr), .bus_rnw(bus_rnw), .bus_wdata(bus_wdata),
    .operand(operand), .irq_sample(irq_sample), .done(done)
  );

  function automatic logic [7:0] memv(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  // Bus memory model
  always_comb begin
    if (bus_addr == {8'h00, mem_zp})              rd_data = mem_lo;
    else if (bus_addr == {8'h00, mem_zp + 8'h01}) rd_data = mem_hi;
    else                                          rd_data = memv(bus_addr);
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL R9 watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // {mode, zp, y, base_lo, base_hi, mod_data}
  localparam logic [41:0] VECS [8] = '{
    {2'b00, 8'h10, 8'h05, 8'h20, 8'h30, 8'h3C},
    {2'b00, 8'h40, 8'hF0, 8'h20, 8'h30, 8'h11},
    {2'b11, 8'h80, 8'h00, 8'hFF, 8'h12, 8'h22},
    {2'b01, 8'h22, 8'h01, 8'h10, 8'h44, 8'h9E},
    {2'b01, 8'hFF, 8'h80, 8'h90, 8'h7F, 8'h6B},
    {2'b10, 8'h50, 8'h03, 8'h00, 8'h60, 8'hC3},
    {2'b10, 8'h60, 8'hFF, 8'h02, 8'hFF, 8'h5D},
    {2'b00, 8'h00, 8'hFF, 8'h01, 8'h00, 8'h77}
  };

  task automatic run_vec(input logic [41:0] v, input bit hold, input string vreq);
    logic [1:0]  m  = v[41:40];
    logic [7:0]  zp = v[39:32];
    logic [7:0]  y  = v[31:24];
    logic [7:0]  lo = v[23:16];
    logic [7:0]  hi = v[15:8];
    logic [7:0]  md = v[7:0];
    logic [15:0] e_addr [8];
    logic        e_rnw  [8];
    logic [7:0]  e_wd   [8];
    logic [15:0] g_addr [12];
    logic        g_rnw  [12];
    logic [7:0]  g_wd   [12];
    logic        g_irq  [12];
    logic [15:0] sum;
    logic [15:0] dummy;
    int ne = 0;
    int ng = 0;
    bit seen = 0;
    bit isw = (m == 2'b01);
    bit ism = (m == 2'b10);
    string rq;

    // Expected trace from the requirements
    sum   = {hi, lo} + {8'h00, y};
    dummy = {hi, sum[7:0]};
    e_addr[ne] = {8'h00, zp};         e_rnw[ne] = 1; e_wd[ne] = 0; ne++;
    e_addr[ne] = {8'h00, zp + 8'h01}; e_rnw[ne] = 1; e_wd[ne] = 0; ne++;
    if (isw || ism || sum[15:8] != hi) begin
      e_addr[ne] = dummy; e_rnw[ne] = 1; e_wd[ne] = 0; ne++;
    end
    if (isw) begin
      e_addr[ne] = sum; e_rnw[ne] = 0; e_wd[ne] = md; ne++;
    end else begin
      e_addr[ne] = sum; e_rnw[ne] = 1; e_wd[ne] = 0; ne++;
      if (ism) begin
        e_addr[ne] = sum; e_rnw[ne] = 0; e_wd[ne] = memv(sum); ne++;
        e_addr[ne] = sum; e_rnw[ne] = 0; e_wd[ne] = md; ne++;
      end
    end

    @(negedge clk);
    mem_zp = zp; mem_lo = lo; mem_hi = hi;
    start = 1; mode = m; y_index = y; zp_ptr = zp; mod_data = md;
    for (int c = 0; c < 12 && !seen; c++) begin
      @(negedge clk);
      if (done) seen = 1;
      else begin
        g_addr[ng] = bus_addr; g_rnw[ng] = bus_rnw; g_wd[ng] = bus_wdata;
        g_irq[ng] = irq_sample; ng++;
      end
      if (!hold) start = 0;
      else begin
        mode = ~mode; y_index = y_index ^ 8'h5A; zp_ptr = zp_ptr + 8'h03;
      end
    end
    start = 0;

    chk(seen, "R9", "done pulse seen", 32'(seen), 32'd1);
    chk(ng == ne, vreq, "access count", 32'(ng), 32'(ne));
    for (int i = 0; i < ne && i < ng; i++) begin
      rq = (i == 0) ? "R1" : (i == 1) ? "R2" : (i == ne - 1) ? "R3" : vreq;
      chk(g_addr[i] == e_addr[i], rq, $sformatf("addr[%0d]", i), 32'(g_addr[i]), 32'(e_addr[i]));
      chk(g_rnw[i] == e_rnw[i], rq, $sformatf("rnw[%0d]", i), 32'(g_rnw[i]), 32'(e_rnw[i]));
      chk(g_wd[i] == e_wd[i], rq, $sformatf("wdata[%0d]", i), 32'(g_wd[i]), 32'(e_wd[i]));
      chk(g_irq[i] == (i == ne - 2), "R8", $sformatf("irq[%0d]", i), 32'(g_irq[i]), 32'(i == ne - 2));
    end
    if (!isw)
      chk(operand == memv(sum), "R13", "operand", 32'(operand), 32'(memv(sum)));
    @(negedge clk);
    chk(bus_addr == 0 && bus_rnw && bus_wdata == 0 && !done && !irq_sample, "R9",
        "idle bus", {bus_addr, 7'd0, bus_rnw, bus_wdata}, 32'h0000_0100);
  endtask

  initial begin
    logic [7:0] op_before;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(bus_addr == 0 && bus_rnw && !done && !irq_sample && operand == 0, "R12",
        "reset state", {bus_addr, 6'd0, bus_rnw, done, operand}, 32'h0000_0200);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // Table walk
    for (int k = 0; k < 8; k++) begin
      string vr;
      case (VECS[k][41:40])
        2'b01:   vr = "R6";
        2'b10:   vr = "R7";
        2'b11:   vr = "R11";
        default: vr = (k == 1 || k == 7) ? "R5" : "R4";
      endcase
      run_vec(VECS[k], 0, vr);
    end

    // R10: inputs scrambled and start held during the sequence
    run_vec(VECS[1], 1, "R10");
    run_vec(VECS[5], 1, "R10");

    // R13: a write leaves the operand from the previous read unchanged
    run_vec(VECS[0], 0, "R4");
    op_before = operand;
    run_vec(VECS[3], 0, "R6");
    chk(operand == op_before, "R13", "operand held over write", 32'(operand), 32'(op_before));

    // R12: reset in the middle of a modify sequence
    @(negedge clk);
    mem_zp = 8'h50; mem_lo = 8'h00; mem_hi = 8'h60;
    start = 1; mode = 2'b10; y_index = 8'h03; zp_ptr = 8'h50;
    @(negedge clk);
    start = 0;
    @(negedge clk);
    rst_n = 0;
    #1;
    chk(bus_addr == 0 && bus_rnw && !done && operand == 0, "R12", "mid-sequence reset",
        {bus_addr, 7'd0, bus_rnw, operand}, 32'h0000_0100);
    @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    run_vec(VECS[2], 0, "R11");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule